// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

The block turns a serial audio stream into parallel left and right sample words. It supports three justification formats and four sample sizes. Each slot can optionally be stretched to 32 bit clocks. It has stereo, mono and left-only repeat operation. The format, size, slot and channel-mode controls use the same encodings as the matching transmitter, so one configuration set drives both directions.

As clock master it generates the bit clock and word-select itself, dividing the system clock. As slave it brings an external bit clock, word-select and data line into the system clock domain and detects rising bit-clock edges there. Completed samples appear right-aligned in 32-bit words, with a one-cycle valid pulse. A consumer acknowledge input lets the block flag a pair that overwrote one that was never taken.

Top module: `i2s_rx_core`

## Requirements
- R1: Capture runs only while `en_i` and `rx_en_i` are both high and `fmt_i` is not reserved. Otherwise no `valid_o` pulse occurs and slot alignment restarts. After enabling, the first word-select change marks the first slot start.
- R2: Data is sampled on rising bit-clock edges. Word-select low is the left slot and high is the right slot. The format codes are as follows. 00 (I2S) places the MSB one bit after the word-select change. 01 (left-justified) places the MSB in the first bit of the slot. 10 (right-justified) takes the last N bits of the slot as the sample. 11 is reserved: nothing is captured.
- R3: Size codes 00, 01, 10 and 11 select N = 8, 16, 24 and 32 bits. Samples are right-aligned in the 32-bit outputs with the upper bits zero.
- R4: With `ext32_i` high, each slot is 32 bit clocks long and received bits outside the sample are dropped. These are the trailing bits for I2S and left-justified formats, and the leading bits for right-justified format.
- R5: In stereo mode, `valid_o` follows the end of each right slot and carries the preceding left word. A right slot with no captured left slot before it in the same enable interval is dropped.
- R6: In mono mode (`mono_i` high), `valid_o` follows every completed slot, with the word on `left_o` and `right_o` zero.
- R7: Repeat mode (`repeat_i` high) applies only with format 00. In that case, `valid_o` follows only left slots, `right_o` is zero, and mono is overridden. With other formats, `repeat_i` has no effect.
- R8: In master mode (`en_i` and `master_i` high), `bclk_o` has a period of 2*HALF_DIV system clocks. `ws_o` toggles only on falling `bclk_o` edges, once every N bits, or every 32 bits with `ext32_i`. When master mode is off, `bclk_o` stays low.
- R9: In slave mode, `bclk_i`, `ws_i` and `sd_i` are resynchronized, and each detected rising `bclk_i` edge samples one bit.
- R10: `valid_o` is a single-cycle pulse. `left_o` and `right_o` change only in cycles where `valid_o` is high.
- R11: `overrun_o` pulses together with `valid_o` when the previous pair was not acknowledged by `ack_i` before that cycle.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| rx_en_i | input | 1 | Receive enable |
| master_i | input | 1 | 1: generate bit clock and word-select |
| fmt_i | input | 2 | Justification format code |
| size_i | input | 2 | Sample size code |
| ext32_i | input | 1 | Force 32-bit slots |
| mono_i | input | 1 | Mono channel mode |
| repeat_i | input | 1 | Left-only repeat mode |
| bclk_i | input | 1 | External bit clock (slave) |
| ws_i | input | 1 | External word-select (slave) |
| sd_i | input | 1 | Serial data |
| ack_i | input | 1 | Consumer has taken the current pair |
| bclk_o | output | 1 | Generated bit clock (master) |
| ws_o | output | 1 | Generated word-select (master) |
| left_o | output | 32 | Left sample word |
| right_o | output | 32 | Right sample word |
| valid_o | output | 1 | New pair available, one cycle |
| overrun_o | output | 1 | Unacknowledged pair overwritten |

## Verification
A wrong bit count or a wrong shift decision shows up on `left_o` or `right_o` at the first valid pulse after the affected slot, as a shifted or truncated word. A wrong slot-to-channel association or a wrong mode choice shows up in the number of valid pulses per frame, or in a nonzero `right_o`. A broken divider or slot counter in master mode shows up within one slot as a wrong `bclk_o` period or a wrong `ws_o` run length. Pending-pair errors show up as a missing or spurious `overrun_o` on the very next pulse.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S   = 2'b00,
    FMT_LEFT  = 2'b01,
    FMT_RIGHT = 2'b10,
    FMT_RSVD  = 2'b11
  } fmt_e;

  // 00..11 -> 8,16,24,32
  function automatic logic [5:0] size_bits(input logic [1:0] code);
    return {1'b0, code, 3'b000} + 6'd8;
  endfunction
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic rise_o,
  output logic ws_o,
  output logic sd_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] b_q, w_q, d_q;
  logic         b_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q      <= '0;
      w_q      <= '0;
      d_q      <= '0;
      b_last_q <= 1'b0;
    end else begin
      b_q      <= {b_q[N-2:0], bclk_i};
      w_q      <= {w_q[N-2:0], ws_i};
      d_q      <= {d_q[N-2:0], sd_i};
      b_last_q <= b_q[N-1];
    end
  end

  assign rise_o = b_q[N-1] & ~b_last_q;
  assign ws_o   = w_q[N-1];
  assign sd_o   = d_q[N-1];
endmodule

// File: rtl/i2s_rx_clkgen.sv
module i2s_rx_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [5:0] slot_len_i,
  output logic       bclk_o,
  output logic       ws_o,
  output logic       rise_o
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

  logic [CW-1:0] div_q;
  logic [5:0]    bpos_q;
  logic          tick;

  assign tick   = (div_q == CW'(HALF_DIV - 1));
  assign rise_o = run_i & tick & ~bclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bpos_q <= '0;
      bclk_o <= 1'b0;
      ws_o   <= 1'b0;
    end else if (!run_i) begin
      div_q  <= '0;
      bpos_q <= '0;
      bclk_o <= 1'b0;
      ws_o   <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      bclk_o <= ~bclk_o;
      if (bclk_o) begin
        // falling edge: advance slot position
        if (bpos_q == slot_len_i - 6'd1) begin
          bpos_q <= '0;
          ws_o   <= ~ws_o;
        end else begin
          bpos_q <= bpos_q + 6'd1;
        end
      end
    end else begin
      div_q <= div_q + CW'(1);
    end
  end
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_rx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          rise_i,
  input  logic          ws_i,
  input  logic          sd_i,
  input  fmt_e          fmt_i,
  input  logic [5:0]    nbits_i,
  output logic          done_o,
  output logic          chan_o,
  output logic [DW-1:0] word_o
);
  logic          ph_v_q, ph_q, eff_v_q, eff_q, started_q;
  logic [5:0]    cnt_q;
  logic [DW-1:0] sh_q;
  logic          eff_now, eff_ok, slot_edge, take_bit;
  logic [DW:0]   full_mask;

  always_comb begin
    // I2S: channel boundary lags word-select by one bit
    eff_now   = (fmt_i == FMT_I2S) ? ph_q : ws_i;
    eff_ok    = (fmt_i == FMT_I2S) ? ph_v_q : 1'b1;
    slot_edge = rise_i && eff_ok && eff_v_q && (eff_now != eff_q);
    take_bit  = (fmt_i == FMT_RIGHT) || (cnt_q < nbits_i);
    full_mask = ({{DW{1'b0}}, 1'b1} << nbits_i) - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_v_q    <= 1'b0;
      ph_q      <= 1'b0;
      eff_v_q   <= 1'b0;
      eff_q     <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      done_o    <= 1'b0;
      chan_o    <= 1'b0;
      word_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (!act_i) begin
        ph_v_q    <= 1'b0;
        eff_v_q   <= 1'b0;
        started_q <= 1'b0;
        cnt_q     <= '0;
        sh_q      <= '0;
      end else if (rise_i) begin
        ph_v_q <= 1'b1;
        ph_q   <= ws_i;
        if (eff_ok) begin
          eff_v_q <= 1'b1;
          eff_q   <= eff_now;
        end
        if (slot_edge) begin
          started_q <= 1'b1;
          cnt_q     <= 6'd1;
          sh_q      <= {{(DW-1){1'b0}}, sd_i};
          if (started_q) begin
            done_o <= 1'b1;
            chan_o <= eff_q;
            word_o <= sh_q & full_mask[DW-1:0];
          end
        end else if (started_q) begin
          if (take_bit) sh_q <= {sh_q[DW-2:0], sd_i};
          if (cnt_q != 6'h3f) cnt_q <= cnt_q + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_rx_pair.sv
module i2s_rx_pair #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          done_i,
  input  logic          chan_i,
  input  logic [DW-1:0] word_i,
  input  logic          mono_i,
  input  logic          rep_i,
  input  logic          ack_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o,
  output logic          overrun_o
);
  logic [DW-1:0] hold_q, emit_l, emit_r;
  logic          have_l_q, pend_q, emit, store_l, drop_l;

  always_comb begin
    emit    = 1'b0;
    store_l = 1'b0;
    drop_l  = 1'b0;
    emit_l  = word_i;
    emit_r  = '0;
    if (done_i) begin
      if (rep_i || mono_i) begin
        emit = rep_i ? !chan_i : 1'b1;
      end else if (!chan_i) begin
        store_l = 1'b1;
      end else if (have_l_q) begin
        emit   = 1'b1;
        drop_l = 1'b1;
        emit_l = hold_q;
        emit_r = word_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      have_l_q  <= 1'b0;
      pend_q    <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      valid_o   <= emit;
      overrun_o <= emit & pend_q & ~ack_i;
      if (emit) begin
        left_o  <= emit_l;
        right_o <= emit_r;
      end
      pend_q <= emit | (pend_q & ~ack_i);
      if (!act_i || drop_l) have_l_q <= 1'b0;
      else if (store_l) begin
        have_l_q <= 1'b1;
        hold_q   <= word_i;
      end
    end
  end
endmodule

// File: rtl/i2s_rx_core.sv
module i2s_rx_core
  import i2s_rx_pkg::*;
#(
  parameter int DW          = 32,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rx_en_i,
  input  logic          master_i,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    size_i,
  input  logic          ext32_i,
  input  logic          mono_i,
  input  logic          repeat_i,
  input  logic          bclk_i,
  input  logic          ws_i,
  input  logic          sd_i,
  input  logic          ack_i,
  output logic          bclk_o,
  output logic          ws_o,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o,
  output logic          overrun_o
);
  fmt_e          fmt;
  logic [5:0]    nbits, slot_len;
  logic          run_m, act, rep_act, mono_act;
  logic          m_rise, s_rise, s_ws, s_sd, rise, ws_sel;
  logic          done, chan;
  logic [DW-1:0] word;

  assign fmt      = fmt_e'(fmt_i);
  assign nbits    = size_bits(size_i);
  assign slot_len = ext32_i ? 6'd32 : nbits;
  assign run_m    = en_i & master_i;
  assign act      = en_i & rx_en_i & (fmt != FMT_RSVD);
  assign rep_act  = repeat_i & (fmt == FMT_I2S);
  assign mono_act = mono_i & ~rep_act;
  assign rise     = master_i ? m_rise : s_rise;
  assign ws_sel   = master_i ? ws_o : s_ws;

  i2s_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .bclk_i, .ws_i, .sd_i,
    .rise_o(s_rise), .ws_o(s_ws), .sd_o(s_sd)
  );

  i2s_rx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i, .rst_ni,
    .run_i(run_m), .slot_len_i(slot_len),
    .bclk_o, .ws_o, .rise_o(m_rise)
  );

  i2s_rx_deser #(.DW(DW)) u_deser (
    .clk_i, .rst_ni,
    .act_i(act), .rise_i(rise), .ws_i(ws_sel), .sd_i(s_sd),
    .fmt_i(fmt), .nbits_i(nbits),
    .done_o(done), .chan_o(chan), .word_o(word)
  );

  i2s_rx_pair #(.DW(DW)) u_pair (
    .clk_i, .rst_ni,
    .act_i(act), .done_i(done), .chan_i(chan), .word_i(word),
    .mono_i(mono_act), .rep_i(rep_act), .ack_i,
    .left_o, .right_o, .valid_o, .overrun_o
  );
endmodule

// File: rtl/i2s_rx_chk.sv
module i2s_rx_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          rx_en_i,
  input logic          master_i,
  input logic [1:0]    fmt_i,
  input logic          mono_i,
  input logic          repeat_i,
  input logic          bclk_o,
  input logic          ws_o,
  input logic [DW-1:0] left_o,
  input logic [DW-1:0] right_o,
  input logic          valid_o,
  input logic          overrun_o
);
  logic act, run;
  assign act = en_i & rx_en_i & (fmt_i != 2'b11);
  assign run = en_i & master_i;

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> ##2 !valid_o);

  assert_mono_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mono_i)) |-> right_o == '0);

  assert_repeat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(repeat_i) && $past(fmt_i) == 2'b00) |-> right_o == '0);

  assert_bclk_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !bclk_o);

  assert_ws_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run) && !$stable(ws_o)) |-> $fell(bclk_o));

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_overrun_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> valid_o);
endmodule

bind i2s_rx_core i2s_rx_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .en_i, .rx_en_i, .master_i, .fmt_i, .mono_i, .repeat_i,
  .bclk_o, .ws_o, .left_o, .right_o, .valid_o, .overrun_o
);

// File: tb/i2s_rx_core_bench.sv
module i2s_rx_core_bench;
  localparam int HALF = 4;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  size;
    logic        ext;
    logic [31:0] l;
    logic [31:0] r;
    logic [31:0] el;
    logic [31:0] er;
  } vec_t;

  // stereo vectors: format, size, ext32, raw slot bits, expected words
  localparam vec_t VECS [11] = '{
    '{2'b00, 2'b01, 1'b0, 32'h0000A5C3, 32'h00001234, 32'h0000A5C3, 32'h00001234},
    '{2'b01, 2'b01, 1'b0, 32'h0000BEEF, 32'h00000F0F, 32'h0000BEEF, 32'h00000F0F},
    '{2'b10, 2'b01, 1'b0, 32'h00008001, 32'h00007FFE, 32'h00008001, 32'h00007FFE},
    '{2'b00, 2'b00, 1'b0, 32'h000000C6, 32'h00000039, 32'h000000C6, 32'h00000039},
    '{2'b01, 2'b10, 1'b0, 32'h00ABCDEF, 32'h00123456, 32'h00ABCDEF, 32'h00123456},
    '{2'b10, 2'b11, 1'b0, 32'hDEADBEEF, 32'h01234567, 32'hDEADBEEF, 32'h01234567},
    '{2'b00, 2'b11, 1'b0, 32'h80000001, 32'hFFFFFFFF, 32'h80000001, 32'hFFFFFFFF},
    '{2'b01, 2'b01, 1'b1, 32'hC3A5FFFF, 32'h1234AAAA, 32'h0000C3A5, 32'h00001234},
    '{2'b10, 2'b00, 1'b1, 32'hFFFFFF5A, 32'hAAAAAA81, 32'h0000005A, 32'h00000081},
    '{2'b00, 2'b10, 1'b1, 32'hABCDEF77, 32'h00000100, 32'h00ABCDEF, 32'h00000001},
    '{2'b10, 2'b10, 1'b1, 32'hFF123456, 32'h00800000, 32'h00123456, 32'h00800000}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        en_i = 0, rx_en_i = 0, master_i = 0, ext32_i = 0, mono_i = 0, repeat_i = 0;
  logic [1:0]  fmt_i = 0, size_i = 0;
  logic        bclk_i = 0, ws_i = 0, sd_s = 0, sd_m = 0, ack_i = 1, mmode = 0;
  logic        sd_i;
  logic        bclk_o, ws_o, valid_o, overrun_o;
  logic [31:0] left_o, right_o;

  int checks = 0, errors = 0, nv = 0, dbl = 0, cyc = 0;
  logic        vprev = 0, finished = 0;
  logic [31:0] cap_l [8];
  logic [31:0] cap_r [8];
  logic        cap_o [8];
  logic [15:0] m_l, m_r;
  logic        m_ws = 0;
  int          m_idx = 0;

  assign sd_i = mmode ? sd_m : sd_s;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  i2s_rx_core u_i2s_rx_core (
    .clk_i, .rst_ni, .en_i, .rx_en_i, .master_i, .fmt_i, .size_i, .ext32_i,
    .mono_i, .repeat_i, .bclk_i, .ws_i, .sd_i, .ack_i,
    .bclk_o, .ws_o, .left_o, .right_o, .valid_o, .overrun_o
  );

  always @(negedge clk_i) begin
    if (valid_o) begin
      if (nv < 8) begin
        cap_l[nv] = left_o;
        cap_r[nv] = right_o;
        cap_o[nv] = overrun_o;
      end
      nv++;
      if (vprev) dbl++;
    end
    vprev = valid_o;
  end

  // master-mode serializer: 16-bit words, MSB first, left-justified
  always @(negedge bclk_o) if (mmode) begin
    #1;
    if (ws_o != m_ws) begin
      m_ws  = ws_o;
      m_idx = 0;
    end else m_idx++;
    sd_m = ws_o ? m_r[4'(15 - m_idx)] : m_l[4'(15 - m_idx)];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [1:0] sz, input logic ex,
                            input logic [31:0] rl, input logic [31:0] rr);
    int n, len, t;
    logic [79:0] wsl, dat;
    n   = (int'(sz) + 1) * 8;
    len = ex ? 32 : n;
    t   = 2 * len + 4;
    wsl = '0;
    dat = '0;
    wsl[0] = 1'b1;
    wsl[1] = 1'b1;
    for (int j = 0; j < len; j++) begin
      dat[2 + j]       = rl[len - 1 - j];
      wsl[2 + len + j] = 1'b1;
      dat[2 + len + j] = rr[len - 1 - j];
    end
    for (int k = 0; k < t; k++) begin
      @(negedge clk_i);
      bclk_i = 1'b0;
      ws_i   = (f == 2'b00) ? wsl[k + 1] : wsl[k];
      sd_s   = dat[k];
      repeat (HALF) @(negedge clk_i);
      bclk_i = 1'b1;
      repeat (HALF - 1) @(negedge clk_i);
    end
    @(negedge clk_i);
    bclk_i = 1'b0;
    ws_i   = 1'b0;
    sd_s   = 1'b0;
  endtask

  task automatic run_frame(input logic [1:0] f, input logic [1:0] sz, input logic ex,
                           input logic [31:0] rl, input logic [31:0] rr);
    @(negedge clk_i);
    rx_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    fmt_i   = f;
    size_i  = sz;
    ext32_i = ex;
    rx_en_i = 1'b1;
    nv      = 0;
    send_frame(f, sz, ex, rl, rr);
    repeat (12) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, ws_run;
    repeat (3) @(negedge clk_i);
    // R12: reset state
    chk(valid_o == 0 && overrun_o == 0 && bclk_o == 0 && ws_o == 0, "R12 ctl in reset",
        {valid_o, overrun_o, bclk_o, ws_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(left_o == 0 && right_o == 0, "R12 data after reset", left_o | right_o, 0);
    en_i = 1'b1;

    // R2 R3 R4 R5 R9: stereo vector walk in slave mode
    foreach (VECS[i]) begin
      run_frame(VECS[i].fmt, VECS[i].size, VECS[i].ext, VECS[i].l, VECS[i].r);
      chk(nv == 1, "R5 one pair per frame", nv, 1);
      chk(cap_l[0] == VECS[i].el, "R2/R3/R4 left word", cap_l[0], VECS[i].el);
      chk(cap_r[0] == VECS[i].er, "R2/R3/R4 right word", cap_r[0], VECS[i].er);
    end

    // R6: mono, one word per slot on left_o
    mono_i = 1'b1;
    run_frame(2'b01, 2'b01, 1'b0, 32'h1111, 32'h2222);
    chk(nv == 2, "R6 mono pulse count", nv, 2);
    chk(cap_l[0] == 32'h1111 && cap_r[0] == 0, "R6 mono first", cap_l[0], 32'h1111);
    chk(cap_l[1] == 32'h2222 && cap_r[1] == 0, "R6 mono second", cap_l[1], 32'h2222);

    // R7: repeat overrides mono, left only
    repeat_i = 1'b1;
    run_frame(2'b00, 2'b01, 1'b0, 32'h4444, 32'h5555);
    chk(nv == 1, "R7 repeat pulse count", nv, 1);
    chk(cap_l[0] == 32'h4444 && cap_r[0] == 0, "R7 repeat left only", cap_l[0], 32'h4444);
    mono_i = 1'b0;
    run_frame(2'b00, 2'b01, 1'b0, 32'h6666, 32'h7777);
    chk(nv == 1 && cap_l[0] == 32'h6666 && cap_r[0] == 0, "R7 repeat stereo", cap_r[0], 0);
    // R7: no effect outside I2S format
    run_frame(2'b01, 2'b01, 1'b0, 32'h4444, 32'h5555);
    chk(nv == 1 && cap_r[0] == 32'h5555, "R7 repeat ignored LJ", cap_r[0], 32'h5555);
    repeat_i = 1'b0;

    // R2: reserved format captures nothing
    run_frame(2'b11, 2'b01, 1'b0, 32'h9999, 32'h8888);
    chk(nv == 0, "R2 reserved no capture", nv, 0);

    // R1: receive enable low blocks capture and leaves outputs
    @(negedge clk_i);
    rx_en_i = 1'b0;
    fmt_i   = 2'b01;
    nv      = 0;
    send_frame(2'b01, 2'b01, 1'b0, 32'hABAB, 32'hCDCD);
    repeat (12) @(negedge clk_i);
    chk(nv == 0, "R1 rx disabled no pulse", nv, 0);
    chk(right_o == 32'h5555, "R1 outputs untouched", right_o, 32'h5555);

    // R11: overrun without ack, cleared by ack
    ack_i = 1'b0;
    run_frame(2'b01, 2'b01, 1'b0, 32'h0101, 32'h0202);
    chk(nv == 1 && cap_o[0] == 1'b0, "R11 first pair no overrun", cap_o[0], 0);
    run_frame(2'b01, 2'b01, 1'b0, 32'h0303, 32'h0404);
    chk(nv == 1 && cap_o[0] == 1'b1, "R11 unacked pair overrun", cap_o[0], 1);
    @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    run_frame(2'b01, 2'b01, 1'b0, 32'h0505, 32'h0606);
    chk(nv == 1 && cap_o[0] == 1'b0, "R11 acked no overrun", cap_o[0], 0);
    ack_i = 1'b1;

    // R8: master mode, LJ 16-bit, slot of 16
    @(negedge clk_i);
    chk(bclk_o == 1'b0, "R8 bclk idle in slave", bclk_o, 0);
    rx_en_i  = 1'b0;
    m_l      = 16'h5AC3;
    m_r      = 16'h0FF0;
    fmt_i    = 2'b01;
    size_i   = 2'b01;
    ext32_i  = 1'b0;
    m_ws     = 1'b0;
    mmode    = 1'b1;
    master_i = 1'b1;
    @(negedge clk_i);
    rx_en_i = 1'b1;
    nv      = 0;
    for (int w = 0; w < 3000 && nv == 0; w++) @(negedge clk_i);
    chk(cap_l[0] == 32'h5AC3, "R8 master capture left", cap_l[0], 32'h5AC3);
    chk(cap_r[0] == 32'h0FF0, "R8 master capture right", cap_r[0], 32'h0FF0);
    @(posedge bclk_o);
    t0 = cyc;
    @(posedge bclk_o);
    chk(cyc - t0 == 2 * HALF, "R8 bclk period", cyc - t0, 2 * HALF);
    for (int pass = 0; pass < 2; pass++) begin
      logic wl;
      @(negedge clk_i);
      wl = ws_o;
      while (ws_o == wl) @(negedge clk_i);
      wl = ws_o;
      ws_run = 0;
      while (ws_o == wl && ws_run < 1000) begin
        @(negedge clk_i);
        ws_run++;
      end
      chk(ws_run == (pass == 0 ? 16 : 32) * 2 * HALF, "R8 ws slot length", ws_run,
          (pass == 0 ? 16 : 32) * 2 * HALF);
      if (pass == 0) begin
        en_i = 1'b0;
        repeat (2) @(negedge clk_i);
        chk(bclk_o == 1'b0 && ws_o == 1'b0, "R8 master idle when disabled", bclk_o, 0);
        ext32_i = 1'b1;
        en_i    = 1'b1;
      end
    end
    mmode    = 1'b0;
    master_i = 1'b0;
    repeat (4) @(negedge clk_i);

    chk(dbl == 0, "R10 valid single cycle", dbl, 0);
    finish_run();
  end
endmodule